// File: doc/BRIEF.md
# Round-Robin Warp Fetch Scheduler

This block sits at the front of a multithreaded SIMT pipeline. Each cycle it picks one warp whose next instruction is to be read from the instruction cache. It drives the cache request with that warp's program counter. On a hit, it hands the returned word to the warp's single instruction-buffer slot one cycle later. It keeps a program counter, a branch-wait flag and a slot-occupied flag for every warp.

A warp can be picked only when it has no unresolved branch and its buffer slot is empty. The slot is claimed at the moment the fetch completes, so the buffer write that follows always has room. Selection rotates round-robin, starting from the warp after the last one served. A cache miss freezes the request until the cache reports a hit. Branch resolution loads a new program counter and makes the warp eligible again. Decode frees a slot with a per-warp consume pulse.

Top module: `warp_fetch_sched`

## Requirements
- R1: After reset no warp waits on a branch, every slot is free, warp w holds PC `w*WARP_STRIDE`, the first request goes to warp 0, and no buffer write is signalled.
- R2: A request goes out in a cycle when at least one warp is eligible. After warp k is served, the next request goes to the first eligible warp in the order k+1, k+2, … with wraparound.
- R3: A fetch claims the warp's slot. A warp whose slot is claimed is skipped until a `slotConsume` pulse for that warp.
- R4: A fetched word with its most significant bit set is a branch. The warp is not requested again until that branch resolves.
- R5: A `brResolveValid` pulse loads `brResolveTarget` into the named warp's PC and clears its branch wait in the same cycle. The warp may be requested in the next cycle, at the new PC.
- R6: While `icRespHit` is low, the request keeps the same warp and address in the following cycle, and the rotation does not advance.
- R7: A fetch completes in cycle t when the request is valid and the hit is high. In cycle t+1, `bufWrValid` is high and carries that warp, its PC and the fetched word. In any other cycle `bufWrValid` is low.
- R8: Each completed fetch advances the warp's PC by one (modulo 2^PC_W). The request address is always the requested warp's current PC.
- R9: In a cycle with no eligible warp and no held request, `icReqValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| icReqValid | output | 1 | Cache request this cycle |
| icReqWarp | output | WARP_W | Warp being fetched |
| icReqAddr | output | PC_W | PC being fetched |
| icRespHit | input | 1 | Cache hit for the current request |
| icRespData | input | INSTR_W | Instruction word; MSB marks a branch |
| brResolveValid | input | 1 | Branch resolution strobe |
| brResolveWarp | input | WARP_W | Warp whose branch resolved |
| brResolveTarget | input | PC_W | Next PC for that warp |
| slotConsume | input | NUM_WARPS | Per-warp pulse: decode emptied the slot |
| bufWrValid | output | 1 | Buffer write strobe |
| bufWrWarp | output | WARP_W | Slot being written |
| bufWrPc | output | PC_W | PC of the written word |
| bufWrData | output | INSTR_W | Written instruction word |

## Verification
A cycle-level model in the bench is run through four stimulus regimes.
- Every request hits and every slot is drained at once. This isolates the plain rotation order.
- Slots are drained rarely. This forces skips over occupied warps and idle cycles with no request, and tells the skip logic apart from the pointer update.
- Misses are frequent. This separates a frozen request from one that drifts to another warp when eligibility changes underneath it.
- Branch words and random resolve targets are added. This shows whether held-back warps stay out of the rotation and whether they resume at the loaded target rather than the incremented PC.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
  // strobes from control to datapath for the current cycle
  typedef struct packed {
    logic fire;     // request accepted by a cache hit
    logic setWait;  // fetched word is a branch
  } fetchStrobe_t;
endpackage

// File: rtl/wfs_ctrl.sv
module wfs_ctrl
  import wfs_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  localparam int WARP_W = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WARPS-1:0] eligible,
  input  logic                 respHit,
  input  logic                 respBranch,
  output logic                 reqValid,
  output logic [WARP_W-1:0]    reqWarp,
  output fetchStrobe_t         strobe
);
  logic [WARP_W-1:0] ptrR;
  logic              holdActive;
  logic [WARP_W-1:0] holdWarp;
  logic              pickValid;
  logic [WARP_W-1:0] pickWarp;

  // first eligible warp at or after the rotation pointer
  always_comb begin
    pickValid = 1'b0;
    pickWarp  = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      int cand;
      cand = int'(ptrR) + i;
      if (cand >= NUM_WARPS) cand = cand - NUM_WARPS;
      if (!pickValid && eligible[cand]) begin
        pickValid = 1'b1;
        pickWarp  = WARP_W'(cand);
      end
    end
  end

  assign reqValid       = holdActive | pickValid;
  assign reqWarp        = holdActive ? holdWarp : pickWarp;
  assign strobe.fire    = reqValid & respHit;
  assign strobe.setWait = reqValid & respHit & respBranch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrR       <= '0;
      holdActive <= 1'b0;
      holdWarp   <= '0;
    end else if (strobe.fire) begin
      ptrR       <= (reqWarp == WARP_W'(NUM_WARPS - 1)) ? '0 : reqWarp + 1'b1;
      holdActive <= 1'b0;
    end else if (reqValid) begin
      holdActive <= 1'b1;
      holdWarp   <= reqWarp;
    end
  end

  // R6: a missed request is repeated unchanged
  p_miss_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !respHit) |=> (reqValid && reqWarp == $past(reqWarp)));
endmodule

// File: rtl/wfs_datapath.sv
module wfs_datapath
  import wfs_pkg::*;
#(
  parameter int NUM_WARPS   = 4,
  parameter int PC_W        = 8,
  parameter int INSTR_W     = 16,
  parameter int WARP_STRIDE = 32,
  localparam int WARP_W = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fetchStrobe_t         strobe,
  input  logic [WARP_W-1:0]    reqWarp,
  output logic [PC_W-1:0]      reqAddr,
  input  logic [INSTR_W-1:0]   respData,
  input  logic                 resolveValid,
  input  logic [WARP_W-1:0]    resolveWarp,
  input  logic [PC_W-1:0]      resolveTarget,
  input  logic [NUM_WARPS-1:0] consume,
  output logic [NUM_WARPS-1:0] eligible,
  output logic                 bufWrValid,
  output logic [WARP_W-1:0]    bufWrWarp,
  output logic [PC_W-1:0]      bufWrPc,
  output logic [INSTR_W-1:0]   bufWrData
);
  logic [PC_W-1:0]      pcR [NUM_WARPS];
  logic [NUM_WARPS-1:0] waitR;
  logic [NUM_WARPS-1:0] busyR;

  assign eligible = ~waitR & ~busyR;
  assign reqAddr  = pcR[reqWarp];

  always_ff @(posedge clk) begin
    for (int w = 0; w < NUM_WARPS; w++) begin
      if (!rstN) begin
        pcR[w]   <= PC_W'(w * WARP_STRIDE);
        waitR[w] <= 1'b0;
        busyR[w] <= 1'b0;
      end else begin
        if (resolveValid && resolveWarp == WARP_W'(w)) begin
          pcR[w]   <= resolveTarget;
          waitR[w] <= 1'b0;
        end else if (strobe.fire && reqWarp == WARP_W'(w)) begin
          pcR[w] <= pcR[w] + 1'b1;
          if (strobe.setWait) waitR[w] <= 1'b1;
        end
        if (strobe.fire && reqWarp == WARP_W'(w)) busyR[w] <= 1'b1;
        else if (consume[w])                      busyR[w] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufWrValid <= 1'b0;
      bufWrWarp  <= '0;
      bufWrPc    <= '0;
      bufWrData  <= '0;
    end else begin
      bufWrValid <= strobe.fire;
      if (strobe.fire) begin
        bufWrWarp <= reqWarp;
        bufWrPc   <= reqAddr;
        bufWrData <= respData;
      end
    end
  end

  // R3: a fetch never lands on a claimed slot
  p_slot_free_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> !busyR[reqWarp]);
  // R4: a warp waiting on a branch is never fetched
  p_no_wait_fetch_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> !waitR[reqWarp]);
  // R5: resolution clears the wait and loads the target
  p_resolve_r5: assert property (@(posedge clk) disable iff (!rstN)
    resolveValid |=> (!waitR[$past(resolveWarp)] && pcR[$past(resolveWarp)] == $past(resolveTarget)));
  // R7: write follows the fetch by one cycle
  p_write_next_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> (bufWrValid && bufWrWarp == $past(reqWarp)));
  // R8: PC advances by one after a fetch
  p_pc_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && !(resolveValid && resolveWarp == reqWarp))
      |=> pcR[$past(reqWarp)] == PC_W'($past(reqAddr) + 1'b1));
endmodule

// File: rtl/warp_fetch_sched.sv
module warp_fetch_sched
  import wfs_pkg::*;
#(
  parameter int NUM_WARPS   = 4,
  parameter int PC_W        = 8,
  parameter int INSTR_W     = 16,
  parameter int WARP_STRIDE = 32,
  localparam int WARP_W = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  output logic                 icReqValid,
  output logic [WARP_W-1:0]    icReqWarp,
  output logic [PC_W-1:0]      icReqAddr,
  input  logic                 icRespHit,
  input  logic [INSTR_W-1:0]   icRespData,
  input  logic                 brResolveValid,
  input  logic [WARP_W-1:0]    brResolveWarp,
  input  logic [PC_W-1:0]      brResolveTarget,
  input  logic [NUM_WARPS-1:0] slotConsume,
  output logic                 bufWrValid,
  output logic [WARP_W-1:0]    bufWrWarp,
  output logic [PC_W-1:0]      bufWrPc,
  output logic [INSTR_W-1:0]   bufWrData
);
  fetchStrobe_t         strobe;
  logic [NUM_WARPS-1:0] eligible;

  wfs_ctrl #(.NUM_WARPS(NUM_WARPS)) uCtrl (
    .clk(clk), .rstN(rstN), .eligible(eligible),
    .respHit(icRespHit), .respBranch(icRespData[INSTR_W-1]),
    .reqValid(icReqValid), .reqWarp(icReqWarp), .strobe(strobe)
  );

  wfs_datapath #(
    .NUM_WARPS(NUM_WARPS), .PC_W(PC_W), .INSTR_W(INSTR_W), .WARP_STRIDE(WARP_STRIDE)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWarp(icReqWarp), .reqAddr(icReqAddr),
    .respData(icRespData), .resolveValid(brResolveValid), .resolveWarp(brResolveWarp),
    .resolveTarget(brResolveTarget), .consume(slotConsume), .eligible(eligible),
    .bufWrValid(bufWrValid), .bufWrWarp(bufWrWarp), .bufWrPc(bufWrPc), .bufWrData(bufWrData)
  );
endmodule

// File: tb/warp_fetch_sched_test.sv
module warp_fetch_sched_test;
  localparam int N = 4;
  localparam int WW = 2;
  localparam int PW = 8;
  localparam int IW = 16;
  localparam int STRIDE = 32;

  logic clk = 1'b0;
  logic rstN;
  logic icReqValid;
  logic [WW-1:0] icReqWarp;
  logic [PW-1:0] icReqAddr;
  logic icRespHit;
  logic [IW-1:0] icRespData;
  logic brResolveValid;
  logic [WW-1:0] brResolveWarp;
  logic [PW-1:0] brResolveTarget;
  logic [N-1:0] slotConsume;
  logic bufWrValid;
  logic [WW-1:0] bufWrWarp;
  logic [PW-1:0] bufWrPc;
  logic [IW-1:0] bufWrData;

  int phase = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  warp_fetch_sched #(.NUM_WARPS(N), .PC_W(PW), .INSTR_W(IW), .WARP_STRIDE(STRIDE)) uut (
    .clk(clk), .rstN(rstN), .icReqValid(icReqValid), .icReqWarp(icReqWarp),
    .icReqAddr(icReqAddr), .icRespHit(icRespHit), .icRespData(icRespData),
    .brResolveValid(brResolveValid), .brResolveWarp(brResolveWarp),
    .brResolveTarget(brResolveTarget), .slotConsume(slotConsume),
    .bufWrValid(bufWrValid), .bufWrWarp(bufWrWarp), .bufWrPc(bufWrPc), .bufWrData(bufWrData)
  );

  function automatic logic [IW-1:0] mkData(logic [PW-1:0] a, int ph);
    logic br;
    br = (ph == 3) && (a % 5 == 2);
    return {br, 7'(a * 3), a};
  endfunction

  // cache model: answers within the cycle
  always_comb icRespData = mkData(icReqAddr, phase);

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference state
  logic [PW-1:0] mPc [N];
  bit mWait [N];
  bit mBusy [N];
  bit mReady [N];
  bit mResolved [N];
  int mPtr;
  bit mHold;
  int mHoldW;
  bit expWrV;
  int expWrW;
  logic [PW-1:0] expWrPc;
  logic [IW-1:0] expWrData;

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int consumeP, missP, resolveP;
    rstN = 1'b0; icRespHit = 1'b1; brResolveValid = 1'b0; brResolveWarp = '0;
    brResolveTarget = '0; slotConsume = '0;
    for (int w = 0; w < N; w++) begin
      mPc[w] = PW'(w * STRIDE); mWait[w] = 0; mBusy[w] = 0; mReady[w] = 0; mResolved[w] = 0;
    end
    mPtr = 0; mHold = 0; mHoldW = 0; expWrV = 0; expWrW = 0; expWrPc = '0; expWrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state visible at the ports
    chk(icReqValid == 1'b1, "R1", int'(icReqValid), 1);
    chk(icReqWarp == 0, "R1", int'(icReqWarp), 0);
    chk(icReqAddr == 0, "R1", int'(icReqAddr), 0);
    chk(bufWrValid == 1'b0, "R1", int'(bufWrValid), 0);

    for (int ph = 0; ph < 4; ph++) begin
      phase = ph;
      case (ph)
        0: begin consumeP = 100; missP = 0;  resolveP = 0;  end
        1: begin consumeP = 15;  missP = 0;  resolveP = 0;  end
        2: begin consumeP = 60;  missP = 40; resolveP = 0;  end
        default: begin consumeP = 50; missP = 20; resolveP = 30; end
      endcase
      for (int cyc = 0; cyc < 400; cyc++) begin
        bit el [N];
        bit expV, fire, anyBusy, anyWait;
        int expW;
        string tag;
        if (cyc != 0 || ph != 0) @(negedge clk);
        // drive inputs
        icRespHit = ($urandom % 100) >= missP;
        slotConsume = '0;
        for (int w = 0; w < N; w++)
          if (mBusy[w] && mReady[w] && ($urandom % 100) < consumeP) slotConsume[w] = 1'b1;
        brResolveValid = 1'b0;
        if (($urandom % 100) < resolveP) begin
          int r;
          r = int'($urandom % N);
          if (mWait[r]) begin
            brResolveValid = 1'b1;
            brResolveWarp = WW'(r);
            brResolveTarget = PW'($urandom);
          end
        end
        #1;
        // expected request
        anyBusy = 0; anyWait = 0;
        for (int w = 0; w < N; w++) begin
          el[w] = !mWait[w] && !mBusy[w];
          if (mBusy[w]) anyBusy = 1;
          if (mWait[w]) anyWait = 1;
        end
        expV = 0; expW = 0;
        if (mHold) begin expV = 1; expW = mHoldW; end
        else
          for (int i = 0; i < N; i++)
            if (!expV && el[(mPtr + i) % N]) begin expV = 1; expW = (mPtr + i) % N; end
        tag = mHold ? "R6" : (anyWait ? "R4" : (anyBusy ? "R3" : "R2"));
        chk(icReqValid == expV, expV ? "R2" : "R9", int'(icReqValid), int'(expV));
        if (expV) begin
          chk(int'(icReqWarp) == expW, tag, int'(icReqWarp), expW);
          chk(icReqAddr == mPc[expW], mResolved[expW] ? "R5" : "R8", int'(icReqAddr), int'(mPc[expW]));
        end
        chk(bufWrValid == expWrV, "R7", int'(bufWrValid), int'(expWrV));
        if (expWrV) begin
          chk(int'(bufWrWarp) == expWrW, "R7", int'(bufWrWarp), expWrW);
          chk(bufWrPc == expWrPc, "R7", int'(bufWrPc), int'(expWrPc));
          chk(bufWrData == expWrData, "R7", int'(bufWrData), int'(expWrData));
          mReady[expWrW] = 1;
        end
        // advance reference across the coming edge
        fire = expV && icRespHit;
        expWrV = fire;
        if (fire) begin
          logic [IW-1:0] d;
          d = mkData(mPc[expW], ph);
          expWrW = expW; expWrPc = mPc[expW]; expWrData = d;
          mPc[expW] = mPc[expW] + 1'b1;
          mBusy[expW] = 1; mReady[expW] = 0; mResolved[expW] = 0;
          if (d[IW-1]) mWait[expW] = 1;
          mPtr = (expW + 1) % N; mHold = 0;
        end else if (expV) begin
          mHold = 1; mHoldW = expW;
        end
        for (int w = 0; w < N; w++)
          if (slotConsume[w]) begin mBusy[w] = 0; mReady[w] = 0; end
        if (brResolveValid) begin
          mPc[brResolveWarp] = brResolveTarget;
          mWait[brResolveWarp] = 0;
          mResolved[brResolveWarp] = 1;
        end
      end
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule